// File: doc/BRIEF.md
# Processor Packet Insert Buffer

This block is a one-burst mailbox between a microprocessor and a streaming egress path. The processor fills it through a small register interface: it first polls a control/status register until the buffer is free. It then writes a flags word, a logical port number, a payload length and up to 256 payload bytes, one entry per write, through a single data insert register. Finally it sets the hand-over bit in the control register.

Once handed over, the buffer belongs to the hardware. The stored payload streams out one byte per accepted beat on a valid/ready interface. Each beat carries the port number. Start-of-packet, end-of-packet and error markers go on the first and last beats. When the last byte has been accepted, the block returns the buffer to the processor by clearing its busy flag. At that moment it emits a one-cycle buffer-empty event meant for an interrupt controller. A burst with an illegal length is dropped without any output, and the buffer is still returned and the event still fires.

Top module: `cpu_burst_mailbox`

## Requirements
- R1: After reset `outValid`, `emptyEvt` and every bit of the control/status register (address `CTRL_ADDR`, default 0) read zero.
- R2: A control write with bit 0 set while the buffer is free hands it to hardware. From the next cycle, status bit 0 (busy) reads one until the burst is released.
- R3: Writes to the data insert register (address `DATA_ADDR`, default 3) while free fill entries in a fixed order: flags, port number (low `PORT_W` bits), length (full register width), then payload bytes 0, 1, 2, … from the low 8 bits of each write.
- R4: A handed-over burst with legal length L (1 ≤ L ≤ `MAX_BYTES`) produces exactly L accepted beats, carrying payload bytes 0 to L-1 in order, each with the stored port number.
- R5: `outSop` is high on the first beat only, and only when flags bit 0 is set.
- R6: `outEop` is high on the last beat only, and only when flags bit 1 is set.
- R7: `outErr` is high on the last beat only, and only when any of flags bits 2 (packet error), 3 (address parity error) or 4 (data parity error) is set. Other flag bits have no effect.
- R8: While `outValid` is high and `outReady` is low, the beat is held unchanged. Busy clears only in the cycle after the last beat is accepted.
- R9: Every clearing of busy is accompanied by `emptyEvt` high for exactly one cycle, in the same cycle that busy first reads zero.
- R10: Data insert writes while busy change no stored entry and do not move the fill pointer. Such a write sets status bit 1. Bit 1 stays set until a control write with bit 1 set clears it.
- R11: A hand-over with length 0 or greater than `MAX_BYTES` produces no beat. Busy clears on the next cycle and `emptyEvt` fires.
- R12: The fill pointer returns to the flags entry whenever busy clears, so the next burst is written from its flags word without any other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | REG_W | Register write data |
| regRdData | output | REG_W | Read data: status {bit1 write-while-busy, bit0 busy} at CTRL_ADDR, zero elsewhere |
| outValid | output | 1 | Egress beat valid |
| outReady | input | 1 | Egress beat accepted when high with outValid |
| outData | output | 8 | Egress payload byte |
| outSop | output | 1 | Start-of-packet marker |
| outEop | output | 1 | End-of-packet marker |
| outErr | output | 1 | Error marker on final byte |
| outPort | output | PORT_W | Logical port number of the burst |
| emptyEvt | output | 1 | One-cycle buffer-returned event |

## Verification
A fill pointer that is off by one shows up on the very next burst. The first beat then carries a header value or a shifted byte, and the scoreboard reports it at the first accepted beat. A read index or length compare that is wrong adds, drops or reorders beats. A busy flag that clears early or late moves `emptyEvt` and the status bit away from the last handshake, so these are checked within a cycle of the final beat. Writes made while the burst is stalled must leave the stalled beat and the following burst untouched. Illegal lengths must produce no beat at all.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Header entries in fill order; payload bytes follow.
  typedef enum logic [1:0] {
    HDR_FLAGS = 2'd0,
    HDR_PORT  = 2'd1,
    HDR_LEN   = 2'd2
  } hdrEntry_e;

  localparam int HDR_WORDS = 3;

  // Flag word bit positions.
  localparam int FLG_SOP      = 0;
  localparam int FLG_EOP      = 1;
  localparam int FLG_PKT_ERR  = 2;
  localparam int FLG_ADDR_PAR = 3;
  localparam int FLG_DATA_PAR = 4;
  localparam int FLG_W        = 5;

  // Strobes from control to datapath.
  typedef struct packed {
    logic flagsWe;
    logic portWe;
    logic lenWe;
    logic byteWe;
    logic firstBeat;
    logic lastBeat;
  } mbxStrb_t;

endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int MAX_BYTES = 256,
  parameter int REG_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int DATA_ADDR = 3,
  localparam int IDX_W    = $clog2(HDR_WORDS + MAX_BYTES + 1),
  localparam int BIDX_W   = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              ctrlGo,
  input  logic              ctrlClrErr,
  input  logic              lenOk,
  input  logic [REG_W-1:0]  payloadLen,
  input  logic              outReady,
  output mbxStrb_t          strb,
  output logic [BIDX_W-1:0] byteIdx,
  output logic [BIDX_W-1:0] rdIdx,
  output logic              outValid,
  output logic              busy,
  output logic              busyWrErr,
  output logic              emptyEvt
);

  localparam logic [IDX_W-1:0] TOTAL_ENTRIES = IDX_W'(HDR_WORDS + MAX_BYTES);
  localparam logic [IDX_W-1:0] FIRST_BYTE    = IDX_W'(HDR_WORDS);

  logic [IDX_W-1:0] wrIdx;
  logic ctrlWr, dataWr, handover, beatDone, lastBeat, releaseNow, fillOk;

  assign ctrlWr   = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR));
  assign dataWr   = regWrEn && (regAddr == ADDR_W'(DATA_ADDR));
  assign handover = ctrlWr && ctrlGo && !busy;
  assign fillOk   = dataWr && !busy && (wrIdx != TOTAL_ENTRIES);

  assign outValid = busy && lenOk;
  assign beatDone = outValid && outReady;
  assign lastBeat = (({{(REG_W-BIDX_W){1'b0}}, rdIdx}) + REG_W'(1)) == payloadLen;
  assign releaseNow = busy && (!lenOk || (beatDone && lastBeat));

  assign byteIdx = BIDX_W'(wrIdx - FIRST_BYTE);

  always_comb begin
    strb           = '0;
    strb.flagsWe   = fillOk && (wrIdx == IDX_W'(HDR_FLAGS));
    strb.portWe    = fillOk && (wrIdx == IDX_W'(HDR_PORT));
    strb.lenWe     = fillOk && (wrIdx == IDX_W'(HDR_LEN));
    strb.byteWe    = fillOk && (wrIdx >= FIRST_BYTE);
    strb.firstBeat = outValid && (rdIdx == '0);
    strb.lastBeat  = outValid && lastBeat;
  end

  // Ownership flag and release event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      emptyEvt <= 1'b0;
    end else begin
      emptyEvt <= releaseNow;
      if (releaseNow)    busy <= 1'b0;
      else if (handover) busy <= 1'b1;
    end
  end

  // Fill pointer
  always_ff @(posedge clk) begin
    if (!rstN)           wrIdx <= '0;
    else if (releaseNow) wrIdx <= '0;
    else if (fillOk)     wrIdx <= wrIdx + IDX_W'(1);
  end

  // Readout index
  always_ff @(posedge clk) begin
    if (!rstN)                       rdIdx <= '0;
    else if (releaseNow)             rdIdx <= '0;
    else if (beatDone && !lastBeat)  rdIdx <= rdIdx + BIDX_W'(1);
  end

  // Sticky write-while-busy status
  always_ff @(posedge clk) begin
    if (!rstN)                      busyWrErr <= 1'b0;
    else if (dataWr && busy)        busyWrErr <= 1'b1;
    else if (ctrlWr && ctrlClrErr)  busyWrErr <= 1'b0;
  end

  // R9
  evt_on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> emptyEvt);
  // R9
  evt_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyEvt |=> !emptyEvt);
  // R12
  wr_ptr_home_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (wrIdx == '0));
  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && dataWr && !releaseNow |=> $stable(wrIdx) && busyWrErr);
  // R11
  bad_len_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lenOk |=> !busy);

endmodule

// File: rtl/mbx_data.sv
module mbx_data
  import mbx_pkg::*;
#(
  parameter int MAX_BYTES = 256,
  parameter int REG_W     = 16,
  parameter int PORT_W    = 8,
  localparam int BIDX_W   = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrb_t          strb,
  input  logic              busy,
  input  logic              outValid,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [BIDX_W-1:0] byteIdx,
  input  logic [BIDX_W-1:0] rdIdx,
  output logic              lenOk,
  output logic [REG_W-1:0]  payloadLen,
  output logic [7:0]        outData,
  output logic              outSop,
  output logic              outEop,
  output logic              outErr,
  output logic [PORT_W-1:0] outPort
);

  logic [FLG_W-1:0]  flagsReg;
  logic [PORT_W-1:0] portReg;
  logic [7:0]        payload [MAX_BYTES];
  logic              anyErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsReg   <= '0;
      portReg    <= '0;
      payloadLen <= '0;
    end else begin
      if (strb.flagsWe) flagsReg   <= regWrData[FLG_W-1:0];
      if (strb.portWe)  portReg    <= regWrData[PORT_W-1:0];
      if (strb.lenWe)   payloadLen <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.byteWe) payload[byteIdx] <= regWrData[7:0];
  end

  assign lenOk  = (payloadLen != '0) && (payloadLen <= REG_W'(MAX_BYTES));
  assign anyErr = flagsReg[FLG_PKT_ERR] | flagsReg[FLG_ADDR_PAR] | flagsReg[FLG_DATA_PAR];

  assign outData = outValid ? payload[rdIdx] : 8'h00;
  assign outPort = portReg;
  assign outSop  = strb.firstBeat && flagsReg[FLG_SOP];
  assign outEop  = strb.lastBeat  && flagsReg[FLG_EOP];
  assign outErr  = strb.lastBeat  && anyErr;

  // R10
  hdr_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(payloadLen) && $stable(flagsReg) && $stable(portReg));

endmodule

// File: rtl/cpu_burst_mailbox.sv
module cpu_burst_mailbox
  import mbx_pkg::*;
#(
  parameter int MAX_BYTES = 256,
  parameter int REG_W     = 16,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int DATA_ADDR = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outSop,
  output logic              outEop,
  output logic              outErr,
  output logic [PORT_W-1:0] outPort,
  output logic              emptyEvt
);

  localparam int BIDX_W = $clog2(MAX_BYTES);

  mbxStrb_t          strb;
  logic [BIDX_W-1:0] byteIdx, rdIdx;
  logic [REG_W-1:0]  payloadLen;
  logic              lenOk, busy, busyWrErr;

  mbx_ctrl #(
    .MAX_BYTES(MAX_BYTES), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .ctrlGo(regWrData[0]), .ctrlClrErr(regWrData[1]),
    .lenOk(lenOk), .payloadLen(payloadLen), .outReady(outReady),
    .strb(strb), .byteIdx(byteIdx), .rdIdx(rdIdx), .outValid(outValid),
    .busy(busy), .busyWrErr(busyWrErr), .emptyEvt(emptyEvt)
  );

  mbx_data #(
    .MAX_BYTES(MAX_BYTES), .REG_W(REG_W), .PORT_W(PORT_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .outValid(outValid),
    .regWrData(regWrData), .byteIdx(byteIdx), .rdIdx(rdIdx),
    .lenOk(lenOk), .payloadLen(payloadLen), .outData(outData),
    .outSop(outSop), .outEop(outEop), .outErr(outErr), .outPort(outPort)
  );

  assign regRdData = (regAddr == ADDR_W'(CTRL_ADDR))
                   ? {{(REG_W-2){1'b0}}, busyWrErr, busy} : '0;

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSop)
                              && $stable(outEop) && $stable(outErr));
  // R5
  sop_first_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !outEop |=> !outSop);

endmodule

// File: tb/cpu_burst_mailbox_tb.sv
module cpu_burst_mailbox_tb_top;

  localparam int CTRL = 0;
  localparam int DATA = 3;

  typedef struct packed {
    logic [7:0] data;
    logic       sop;
    logic       eop;
    logic       err;
    logic [7:0] port;
  } beat_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        outValid, outReady, outSop, outEop, outErr, emptyEvt;
  logic [7:0]  outData, outPort;

  int checks = 0;
  int fails = 0;
  int evtCount = 0;
  int expEvt = 0;
  int readyMode = 1;
  int cyc = 0;
  bit finished = 0;
  beat_t expQ[$];

  always #2.5 clk = ~clk;

  cpu_burst_mailbox dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outSop(outSop), .outEop(outEop),
    .outErr(outErr), .outPort(outPort), .emptyEvt(emptyEvt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor / scoreboard
  initial begin
    outReady = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      case (readyMode)
        0: outReady = 1'b0;
        1: outReady = 1'b1;
        default: outReady = (cyc % 3) != 0;
      endcase
      if (emptyEvt) evtCount++;
      if (rstN && outValid && outReady) begin
        beat_t got, exp;
        got = '{data: outData, sop: outSop, eop: outEop, err: outErr, port: outPort};
        if (expQ.size() == 0) begin
          check(1'b0, "R4/R11", "unexpected beat", int'(got), 0);
        end else begin
          exp = expQ.pop_front();
          check(got == exp, "R4/R5/R6/R7", "beat", int'(got), int'(exp));
        end
      end
    end
  end

  task automatic regWrite(input int addr, input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(addr); regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 4'(CTRL);
  endtask

  // Driver: fills the buffer, pushes expected beats, hands over.
  task automatic sendBurst(input logic [15:0] flg, input logic [7:0] port,
                           input logic [15:0] len, input logic [7:0] seed);
    int nb;
    regWrite(DATA, flg);
    regWrite(DATA, {8'h00, port});
    regWrite(DATA, len);
    nb = (len > 256) ? 4 : int'(len);
    for (int i = 0; i < nb; i++) regWrite(DATA, {8'hA0, 8'(seed + i * 7)});
    if (len >= 1 && len <= 256) begin
      for (int i = 0; i < int'(len); i++) begin
        expQ.push_back('{data: 8'(seed + i * 7),
                         sop: (i == 0) && flg[0],
                         eop: (i == int'(len) - 1) && flg[1],
                         err: (i == int'(len) - 1) && (|flg[4:2]),
                         port: port});
      end
    end
    expEvt++;
    regWrite(CTRL, 16'h0001);
    // R2: busy visible right after hand-over
    check(regRdData[0] == 1'b1, "R2", "busy after handover", regRdData[0], 1);
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    regAddr = 4'(CTRL);
    while (regRdData[0] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(regRdData[0] == 1'b0, req, "busy released", regRdData[0], 0);
    check(expQ.size() == 0, req, "all beats drained", expQ.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid reset", outValid, 0);
    check(emptyEvt == 1'b0, "R1", "emptyEvt reset", emptyEvt, 0);
    check(regRdData == 16'h0, "R1", "status reset", regRdData, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5 R6: short burst with both markers
    readyMode = 1;
    sendBurst(16'h0003, 8'h12, 16'd4, 8'h10);
    waitIdle("R4");
    check(evtCount == expEvt, "R9", "event count", evtCount, expEvt);

    // R4 R8: full-length burst under backpressure, no markers (R12: refill)
    readyMode = 2;
    sendBurst(16'h0000, 8'h07, 16'd256, 8'h33);
    waitIdle("R8");

    // R7: single byte with address parity error, plus an unused flag bit
    readyMode = 1;
    sendBurst(16'h00EB, 8'h3C, 16'd1, 8'hC4);
    waitIdle("R7");

    // R7: packet error on a middle fragment
    readyMode = 2;
    sendBurst(16'h0004, 8'h55, 16'd5, 8'h80);
    waitIdle("R7");

    // R10: writes while stalled are ignored and flagged
    readyMode = 0;
    sendBurst(16'h0012, 8'h21, 16'd8, 8'h61);
    regWrite(DATA, 16'h00FF);
    regWrite(DATA, 16'h0099);
    regWrite(CTRL, 16'h0001);
    check(regRdData[1] == 1'b1, "R10", "write-while-busy bit", regRdData[1], 1);
    check(outValid == 1'b1 && outData == 8'h61, "R10", "stalled beat kept",
          outData, 8'h61);
    readyMode = 1;
    waitIdle("R10");
    regWrite(CTRL, 16'h0002);
    check(regRdData == 16'h0, "R10", "status cleared, no handover", regRdData, 0);

    // R12: next burst starts at the flags entry
    sendBurst(16'h0001, 8'h44, 16'd3, 8'h02);
    waitIdle("R12");

    // R11: illegal lengths
    sendBurst(16'h0003, 8'h01, 16'd0, 8'h00);
    waitIdle("R11");
    sendBurst(16'h0003, 8'h01, 16'd300, 8'h00);
    waitIdle("R11");
    repeat (3) @(negedge clk);
    check(evtCount == expEvt, "R9/R11", "event count", evtCount, expEvt);
    check(emptyEvt == 1'b0, "R9", "event returns low", emptyEvt, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule